// File: doc/BRIEF.md
# Processor Supervisor with Watchdog Reset

This block supervises a processor from the digital side. A comparator output reports whether the core supply is above its reset threshold. While it is not, the block holds the processor in reset and keeps an external memory chip-enable inactive, so the memory cannot be written. When the supply recovers, reset stays asserted for a fixed pulse period. This gives the processor clock time to settle before code runs.

Once out of reset, software must keep toggling a strobe line. Rising and falling edges both count. If the strobe stays still for a full timeout period, the block issues a reset pulse of the same width as the power-up pulse. It repeats that pulse every timeout period for as long as the strobe stays quiet. A separate fault flag records that the watchdog expired and stays set until the strobe moves again. A second comparator input drives a power-fail warning line that software can use to save state before the supply drops far enough to cause a reset.

All timing is counted in ticks of a slow timebase. Each tick is `TICK_DIV` clock cycles long, and the prescaler restarts whenever a timed phase begins. The three comparator and strobe inputs are asynchronous and each passes through a two-flop synchroniser.

Top module: `proc_supervisor`

## Requirements
- R1: Within three clock cycles of `supply_ok` going low, `cpu_rst_n` is 0 and `mem_ce_n_out` is 1. Both stay that way while `supply_ok` stays low.
- R2: After `supply_ok` returns high, `cpu_rst_n` rises exactly `2 + PULSE_TICKS*TICK_DIV` clock cycles later.
- R3: Any edge on `wd_strobe`, rising or falling, restarts the watchdog period. This holds even when the edge is recognised in the same cycle the period would have expired. A strobe toggled faster than the timeout never causes a reset.
- R4: If the strobe does not move and `wd_enable` is 1, `cpu_rst_n` falls `WDOG_TICKS*TICK_DIV` cycles after it rose. It then stays low for `PULSE_TICKS*TICK_DIV` cycles.
- R5: While the strobe stays quiet, another reset pulse follows `WDOG_TICKS*TICK_DIV` cycles after each watchdog pulse ends.
- R6: `wd_fault_n` goes to 0 in the same cycle that a watchdog pulse begins. It stays 0 through later pulses and supply changes, and returns to 1 within four cycles of a strobe edge.
- R7: `cpu_rst` is always the complement of `cpu_rst_n`.
- R8: While the synchronised supply is good, `mem_ce_n_out` equals `mem_ce_n_in` in the same cycle.
- R9: `pwr_warn_n` follows `early_ok` with a two-cycle synchroniser delay. Warning asserted is 0.
- R10: While `wd_enable` is 0, no watchdog reset occurs and `wd_fault_n` is 1.
- R11: During and just after `rst_n` low, `cpu_rst_n` is 0, `cpu_rst` is 1, `wd_fault_n` is 1 and `pwr_warn_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| supply_ok | input | 1 | Supply comparator, 1 = above reset threshold |
| early_ok | input | 1 | Power-fail comparator, 1 = monitored voltage above its threshold |
| wd_strobe | input | 1 | Watchdog service strobe, any edge services |
| wd_enable | input | 1 | 1 = watchdog active |
| mem_ce_n_in | input | 1 | Memory chip-enable from the processor, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rst | output | 1 | Processor reset, active high |
| wd_fault_n | output | 1 | Sticky watchdog fault, active low |
| pwr_warn_n | output | 1 | Early power-fail warning, active low |
| mem_ce_n_out | output | 1 | Gated memory chip-enable, active low |

## Verification
A strobe edge and the watchdog expiry can both be recognised at the same clock edge. The service must win. The bench provokes this by timing the strobe toggle from the observed reset release, so that the edge, delayed by the synchroniser and the edge detector, lands on the final tick of the period. It then requires that reset stays high for nearly another full period and that the fault flag stays clear. The supply going low while the chip-enable input is active is the other overlap. It is judged by requiring the memory enable to be blocked in the same cycle that reset asserts.

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
  parameter int TICK_DIV    = 1000,
  parameter int PULSE_TICKS = 50,
  parameter int WDOG_TICKS  = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic early_ok,
  input  logic wd_strobe,
  input  logic wd_enable,
  input  logic mem_ce_n_in,
  output logic cpu_rst_n,
  output logic cpu_rst,
  output logic wd_fault_n,
  output logic pwr_warn_n,
  output logic mem_ce_n_out
);

  localparam int PRW = (TICK_DIV    > 1) ? $clog2(TICK_DIV)    : 1;
  localparam int PCW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam int WCW = (WDOG_TICKS  > 1) ? $clog2(WDOG_TICKS)  : 1;
  localparam logic [PRW-1:0] PRE_LAST   = PRW'(TICK_DIV - 1);
  localparam logic [PCW-1:0] PULSE_LAST = PCW'(PULSE_TICKS - 1);
  localparam logic [WCW-1:0] WDOG_LAST  = WCW'(WDOG_TICKS - 1);

  logic [1:0] sup_sync, early_sync, stb_sync;
  logic       stb_prev;
  logic       supply_s, strobe_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sup_sync   <= 2'b00;
      early_sync <= 2'b00;
      stb_sync   <= 2'b00;
      stb_prev   <= 1'b0;
    end else begin
      sup_sync   <= {sup_sync[0], supply_ok};
      early_sync <= {early_sync[0], early_ok};
      stb_sync   <= {stb_sync[0], wd_strobe};
      stb_prev   <= stb_sync[1];
    end

  assign supply_s    = sup_sync[1];
  assign strobe_edge = stb_sync[1] ^ stb_prev;

  logic           in_pulse;
  logic [PRW-1:0] pre_cnt;
  logic [PCW-1:0] pulse_cnt;
  logic [WCW-1:0] wd_cnt;
  logic           tick, timeout;

  assign tick    = (pre_cnt == PRE_LAST);
  assign timeout = supply_s && !in_pulse && !strobe_edge && wd_enable
                   && tick && (wd_cnt == WDOG_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_pulse  <= 1'b1;
      pre_cnt   <= '0;
      pulse_cnt <= '0;
      wd_cnt    <= '0;
    end else if (!supply_s) begin
      in_pulse  <= 1'b1;
      pre_cnt   <= '0;
      pulse_cnt <= '0;
      wd_cnt    <= '0;
    end else if (in_pulse) begin
      wd_cnt  <= '0;
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        if (pulse_cnt == PULSE_LAST) begin
          in_pulse  <= 1'b0;
          pulse_cnt <= '0;
        end else begin
          pulse_cnt <= pulse_cnt + 1'b1;
        end
      end
    end else if (strobe_edge || !wd_enable) begin
      wd_cnt  <= '0;
      pre_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (timeout) begin
        in_pulse <= 1'b1;
        wd_cnt   <= '0;
      end else if (tick) begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end

  logic fault_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         fault_q <= 1'b0;
    else if (!wd_enable || strobe_edge) fault_q <= 1'b0;
    else if (timeout)                   fault_q <= 1'b1;

  assign cpu_rst_n    = supply_s && !in_pulse;
  assign cpu_rst      = !cpu_rst_n;
  assign wd_fault_n   = !fault_q;
  assign pwr_warn_n   = early_sync[1];
  assign mem_ce_n_out = mem_ce_n_in || !supply_s;

  assert_low_supply_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_s |=> in_pulse);

  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_pulse) |-> $past(tick) && $past(supply_s));

  assert_strobe_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_edge && supply_s && !in_pulse |=> wd_cnt == '0 && !$rose(in_pulse));

  assert_fault_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_fault_n) |-> $rose(in_pulse));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> wd_fault_n);

  always_ff @(posedge clk)
    if (rst_n) begin
      assert_pulse_bound_R2: assert (pulse_cnt <= PULSE_LAST);
      assert_wdog_bound_R4:  assert (wd_cnt <= WDOG_LAST);
    end

endmodule

// File: tb/proc_supervisor_test.sv
module proc_supervisor_test;
  localparam int TD = 2;
  localparam int PT = 5;
  localparam int WT = 20;
  localparam int PULSE_CYC = PT * TD;
  localparam int WDOG_CYC  = WT * TD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, early_ok = 1'b1, wd_strobe = 1'b0, wd_enable = 1'b1;
  logic mem_ce_n_in = 1'b1;
  logic cpu_rst_n, cpu_rst, wd_fault_n, pwr_warn_n, mem_ce_n_out;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  proc_supervisor #(.TICK_DIV(TD), .PULSE_TICKS(PT), .WDOG_TICKS(WT)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .early_ok(early_ok),
    .wd_strobe(wd_strobe), .wd_enable(wd_enable), .mem_ce_n_in(mem_ce_n_in),
    .cpu_rst_n(cpu_rst_n), .cpu_rst(cpu_rst), .wd_fault_n(wd_fault_n),
    .pwr_warn_n(pwr_warn_n), .mem_ce_n_out(mem_ce_n_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (cpu_rst_n !== lvl && n < 1000) begin
      @(negedge clk);
      n++;
      check(cpu_rst === ~cpu_rst_n, "R7", cpu_rst, ~cpu_rst_n);
    end
  endtask

  task automatic test_reset_state();
    waitn(2);
    check(cpu_rst_n === 1'b0, "R11 cpu_rst_n", cpu_rst_n, 0);
    check(cpu_rst === 1'b1, "R11 cpu_rst", cpu_rst, 1);
    check(wd_fault_n === 1'b1, "R11 wd_fault_n", wd_fault_n, 1);
    check(pwr_warn_n === 1'b0, "R11 pwr_warn_n", pwr_warn_n, 0);
    rst_n = 1'b1;
    waitn(3);
    check(pwr_warn_n === 1'b1, "R9 warn idle", pwr_warn_n, 1);
  endtask

  task automatic test_powerup();
    int n;
    supply_ok = 1'b1;
    run_len(1'b1, n);
    check(n == 2 + PULSE_CYC, "R2 power-up pulse", n, 2 + PULSE_CYC);
  endtask

  task automatic test_timeout();
    int n;
    run_len(1'b0, n);
    check(n == WDOG_CYC, "R4 timeout period", n, WDOG_CYC);
    check(wd_fault_n === 1'b0, "R6 fault set", wd_fault_n, 0);
    run_len(1'b1, n);
    check(n == PULSE_CYC, "R4 pulse width", n, PULSE_CYC);
    run_len(1'b0, n);
    check(n == WDOG_CYC, "R5 repeat period", n, WDOG_CYC);
    check(wd_fault_n === 1'b0, "R6 fault sticky", wd_fault_n, 0);
    wd_strobe = ~wd_strobe;
    waitn(4);
    check(wd_fault_n === 1'b1, "R6 fault cleared", wd_fault_n, 1);
    run_len(1'b1, n);
  endtask

  task automatic test_service();
    int lows = 0;
    for (int k = 0; k < 12; k++) begin
      wd_strobe = ~wd_strobe;
      for (int i = 0; i < WDOG_CYC / 2; i++) begin
        @(negedge clk);
        if (cpu_rst_n !== 1'b1) lows++;
      end
    end
    check(lows == 0, "R3 serviced no reset", lows, 0);
  endtask

  task automatic test_disable();
    int lows = 0;
    wd_enable = 1'b0;
    for (int i = 0; i < 3 * WDOG_CYC; i++) begin
      @(negedge clk);
      if (cpu_rst_n !== 1'b1 || wd_fault_n !== 1'b1) lows++;
    end
    check(lows == 0, "R10 disabled no reset", lows, 0);
    wd_strobe = ~wd_strobe;
    wd_enable = 1'b1;
    waitn(3);
  endtask

  task automatic test_mem_and_supply();
    int n;
    mem_ce_n_in = 1'b0;
    waitn(1);
    check(mem_ce_n_out === 1'b0, "R8 ce follows low", mem_ce_n_out, 0);
    mem_ce_n_in = 1'b1;
    waitn(1);
    check(mem_ce_n_out === 1'b1, "R8 ce follows high", mem_ce_n_out, 1);
    mem_ce_n_in = 1'b0;
    supply_ok = 1'b0;
    waitn(3);
    check(cpu_rst_n === 1'b0, "R1 reset on low supply", cpu_rst_n, 0);
    check(mem_ce_n_out === 1'b1, "R1 ce blocked", mem_ce_n_out, 1);
    waitn(20);
    check(cpu_rst_n === 1'b0 && mem_ce_n_out === 1'b1, "R1 held while low",
          {cpu_rst_n, mem_ce_n_out}, 1);
    supply_ok = 1'b1;
    run_len(1'b1, n);
    check(n == 2 + PULSE_CYC, "R2 recovery pulse", n, 2 + PULSE_CYC);
    check(mem_ce_n_out === 1'b0, "R8 ce restored", mem_ce_n_out, 0);
  endtask

  task automatic test_race();
    int lows = 0;
    waitn(WDOG_CYC - 3);
    wd_strobe = ~wd_strobe;
    for (int i = 0; i < WDOG_CYC - 2; i++) begin
      @(negedge clk);
      if (cpu_rst_n !== 1'b1) lows++;
    end
    check(lows == 0, "R3 edge beats expiry", lows, 0);
    check(wd_fault_n === 1'b1, "R3 no fault on race", wd_fault_n, 1);
  endtask

  task automatic test_warn();
    early_ok = 1'b0;
    waitn(1);
    check(pwr_warn_n === 1'b1, "R9 warn delay", pwr_warn_n, 1);
    waitn(1);
    check(pwr_warn_n === 1'b0, "R9 warn asserted", pwr_warn_n, 0);
    early_ok = 1'b1;
    waitn(2);
    check(pwr_warn_n === 1'b1, "R9 warn released", pwr_warn_n, 1);
  endtask

  initial begin
    test_reset_state();
    test_powerup();
    test_timeout();
    test_service();
    test_disable();
    test_mem_and_supply();
    test_race();
    test_warn();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule